// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block steers one I2C master transaction on behalf of a CPU. It holds the latched control bits (master, direction, repeat mode, stop request), decides when to ask a byte-level bus engine for a start condition, a byte write, a byte read or a stop condition, and moves each byte between the engine and an external packing buffer that is at most four bytes deep. Every engine request is a single-cycle pulse. The engine replies with a `done` pulse that carries an acknowledge bit and, after a read, the received byte.

There are two transfer modes. In counted mode a working counter is loaded from the programmed count when the target acknowledges the start. Each byte moved decrements it. When it reaches zero, the sequencer either closes the bus (if a stop is pending) or reports access-ready and drops out of master. In repeat mode the counter is left alone: a transmit pass drains the buffer, a receive pass fills it, and a pending stop closes the bus. Once the start has been acknowledged, the sequencer runs one pass each time the CPU touches the data register (`data_kick`) and then waits. Any no-acknowledge raises the NACK flag and cancels the pending stop.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write carrying start is accepted only while the sequencer is idle, with enable and master set and 10-bit addressing clear. If enable is set but master is clear or 10-bit addressing is set, `start_rej` pulses and no bus request is made. With enable clear, the start is ignored.
- R2: An accepted start pulses `eng_start` with `eng_addr` equal to `tgt_addr` and `eng_read` equal to the inverse of the transmit bit. In the same cycle it pulses `buf_flush`. The engine never sees two requests in one cycle.
- R3: A start that is not acknowledged sets `flag_nack` and clears `stop_pend`. It leaves `bus_open` low and moves no data.
- R4: An acknowledged start sets `bus_open`, loads `work_count` from `prog_count` and immediately runs one pass.
- R5: In counted transmit, a pass sends the buffer's front byte (`buf_pop` with `eng_send`) while no NACK has occurred in the pass, the count is nonzero and the buffer holds a byte. Each sent byte decrements `work_count`.
- R6: At the end of a counted-transmit pass, `flag_xrdy` is 1 if every byte was acknowledged and the count is nonzero; otherwise it is 0.
- R7: In counted receive, a pass reads bytes into the buffer (`buf_push`) while the count is nonzero and fewer than four bytes are held. At the end of the pass, `flag_rrdy` is 1 exactly when the buffer is nonempty.
- R8: When the count is zero and a stop is pending, the sequencer pulses `eng_stop`. On its completion it clears `stop_pend` and `bus_open`, reloads `work_count` from `prog_count` and pulses `buf_flush`. When the count is zero without a stop, it sets `flag_ardy` and clears `master_on`. A counted transmit that ends at zero also sets `flag_ardy` and clears `master_on` when a stop is pending.
- R9: In repeat mode the count is neither tested nor decremented. With a stop pending, a pass only closes the bus. Otherwise a transmit pass sends every held byte and sets `flag_xrdy`, and a receive pass fills the buffer to four bytes and sets `flag_rrdy`.
- R10: A data byte that is not acknowledged sets `flag_nack` and clears `stop_pend`, and no further byte is sent in that pass.
- R11: `work_count` shows the live working counter, not the programmed count.
- R12: While the bus is closed, `data_kick` makes no engine request. While the bus is open, each `data_kick` in idle runs exactly one pass.
- R13: `flag_clr` clears flags with bit 0 = NACK, bit 1 = access-ready, bit 2 = transmit-ready and bit 3 = receive-ready. A flag update in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_master | input | 1 | Master bit of the control write |
| ctl_tx | input | 1 | Transmit-direction bit |
| ctl_addr10 | input | 1 | 10-bit addressing request (rejected) |
| ctl_repeat | input | 1 | Repeat-mode bit |
| ctl_stop | input | 1 | Stop request bit |
| ctl_start | input | 1 | Start request bit |
| tgt_addr | input | ADDR_W | Target address |
| prog_count | input | CNT_W | Programmed byte count |
| data_kick | input | 1 | CPU accessed the data register |
| flag_clr | input | 4 | Write-one-to-clear flag strobes |
| buf_level | input | LVL_W | Bytes held in the packing buffer |
| buf_rd_data | input | BYTE_W | Front byte of the packing buffer |
| buf_pop | output | 1 | Remove the front byte |
| buf_push | output | 1 | Append `buf_wr_data` |
| buf_wr_data | output | BYTE_W | Received byte |
| buf_flush | output | 1 | Empty the buffer |
| eng_start | output | 1 | Start-condition request |
| eng_addr | output | ADDR_W | Address for the start |
| eng_read | output | 1 | Direction for the start (1 = read) |
| eng_send | output | 1 | Byte-write request |
| eng_tx_byte | output | BYTE_W | Byte to write |
| eng_recv | output | 1 | Byte-read request |
| eng_stop | output | 1 | Stop-condition request |
| eng_done | input | 1 | Engine finished the current request |
| eng_ack | input | 1 | Acknowledge seen for start or write |
| eng_rx_byte | input | BYTE_W | Byte returned by a read |
| flag_nack | output | 1 | No-acknowledge flag |
| flag_ardy | output | 1 | Access-ready flag |
| flag_xrdy | output | 1 | Transmit-ready flag |
| flag_rrdy | output | 1 | Receive-ready flag |
| work_count | output | CNT_W | Working counter |
| master_on | output | 1 | Latched master bit |
| stop_pend | output | 1 | Pending stop request |
| bus_open | output | 1 | Transaction in progress on the bus |
| start_rej | output | 1 | Illegal start rejected |

## Verification
A wrong sequencer state shows up within one engine round trip. A stray or missing request pulse, or a byte sent out of buffer order, is caught by the scoreboard at the engine port in the very cycle the request appears. A counter that is off by one shows on `work_count` after the pass. It also shifts the cycle in which `eng_stop` appears or `flag_ardy` rises, which the flag checks taken a few dozen cycles after each kick expose. A stop or NACK path that fails to cancel state leaves `stop_pend` or `bus_open` wrong at the next check.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_START = 3'd1,
      S_RUN   = 3'd2,
      S_SEND  = 3'd3,
      S_RECV  = 3'd4,
      S_STOP  = 3'd5
   } seq_state_t;

   localparam int unsigned FLAG_N    = 4;
   localparam int unsigned FL_NACK   = 0;
   localparam int unsigned FL_ARDY   = 1;
   localparam int unsigned FL_XRDY   = 2;
   localparam int unsigned FL_RRDY   = 3;
endpackage

// File: rtl/i2c_seq_ctl.sv
module i2c_seq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic accept,
   input  logic en,
   input  logic master,
   input  logic tx,
   input  logic addr10,
   input  logic rpt,
   input  logic stop,
   input  logic start,
   input  logic clr_master,
   input  logic clr_stop,
   output logic q_master,
   output logic q_tx,
   output logic q_rpt,
   output logic q_stop,
   output logic go,
   output logic rej
);
   logic take;
   assign take = wr && accept;
   assign go   = take && start && en && master && !addr10;
   assign rej  = take && start && en && (!master || addr10);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_master <= 1'b0;
         q_tx     <= 1'b0;
         q_rpt    <= 1'b0;
         q_stop   <= 1'b0;
      end else if (take) begin
         q_master <= master;
         q_tx     <= tx;
         q_rpt    <= rpt;
         q_stop   <= stop;
      end else begin
         if (clr_master) q_master <= 1'b0;
         if (clr_stop)   q_stop   <= 1'b0;
      end
   end

   // R1: a rejected start never reaches the engine
   p_rej_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rej |-> !go);
endmodule

// File: rtl/i2c_seq_cnt.sv
module i2c_seq_cnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= cnt - 1'b1;
   end
   assign zero = (cnt == '0);

   // R11: the working counter never wraps below zero
   p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> !zero);
endmodule

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] upd,
   input  logic [N-1:0] val,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (upd[i]) q[i] <= val[i];
         else if (clr[i]) q[i] <= 1'b0;
      end
   end

   // R13: an update wins over a clear in the same cycle
   p_upd_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
      upd[0] |=> q[0] == $past(val[0]));
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
   import i2c_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned BUF_DEPTH = 4,
   localparam int unsigned LVL_W    = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   input  logic              ctl_master,
   input  logic              ctl_tx,
   input  logic              ctl_addr10,
   input  logic              ctl_repeat,
   input  logic              ctl_stop,
   input  logic              ctl_start,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [CNT_W-1:0]  prog_count,
   input  logic              data_kick,
   input  logic [3:0]        flag_clr,
   input  logic [LVL_W-1:0]  buf_level,
   input  logic [BYTE_W-1:0] buf_rd_data,
   output logic              buf_pop,
   output logic              buf_push,
   output logic [BYTE_W-1:0] buf_wr_data,
   output logic              buf_flush,
   output logic              eng_start,
   output logic [ADDR_W-1:0] eng_addr,
   output logic              eng_read,
   output logic              eng_send,
   output logic [BYTE_W-1:0] eng_tx_byte,
   output logic              eng_recv,
   output logic              eng_stop,
   input  logic              eng_done,
   input  logic              eng_ack,
   input  logic [BYTE_W-1:0] eng_rx_byte,
   output logic              flag_nack,
   output logic              flag_ardy,
   output logic              flag_xrdy,
   output logic              flag_rrdy,
   output logic [CNT_W-1:0]  work_count,
   output logic              master_on,
   output logic              stop_pend,
   output logic              bus_open,
   output logic              start_rej
);
   if (BUF_DEPTH < 1 || BUF_DEPTH > 8) begin : g_chk_depth
      $error("BUF_DEPTH must lie in 1..8");
   end
   if (ADDR_W < 7 || BYTE_W != 8 || CNT_W < 2) begin : g_chk_width
      $error("ADDR_W >= 7, BYTE_W == 8 and CNT_W >= 2 are required");
   end

   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(BUF_DEPTH);

   seq_state_t st;
   logic c_tx, c_rpt, c_stop, go;
   logic clr_master, clr_stop, cnt_zero, cnt_load, cnt_dec;
   logic ack_ok;
   logic in_run, do_send, do_recv, do_stop, pass_end, pass_eval;
   logic start_done, send_done, recv_done, stop_done;
   logic [FLAG_N-1:0] fl_upd, fl_val, fl_q;

   i2c_seq_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .accept(st == S_IDLE),
      .en(ctl_en), .master(ctl_master), .tx(ctl_tx), .addr10(ctl_addr10),
      .rpt(ctl_repeat), .stop(ctl_stop), .start(ctl_start),
      .clr_master(clr_master), .clr_stop(clr_stop),
      .q_master(master_on), .q_tx(c_tx), .q_rpt(c_rpt), .q_stop(c_stop),
      .go(go), .rej(start_rej)
   );

   i2c_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(prog_count),
      .dec(cnt_dec), .cnt(work_count), .zero(cnt_zero)
   );

   i2c_seq_flags #(.N(FLAG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .upd(fl_upd), .val(fl_val),
      .clr(flag_clr), .q(fl_q)
   );

   assign flag_nack = fl_q[FL_NACK];
   assign flag_ardy = fl_q[FL_ARDY];
   assign flag_xrdy = fl_q[FL_XRDY];
   assign flag_rrdy = fl_q[FL_RRDY];
   assign stop_pend = c_stop;

   // pass decision
   always_comb begin
      in_run   = (st == S_RUN);
      do_stop  = in_run && c_stop && (c_rpt || cnt_zero);
      do_send  = in_run && !do_stop && c_tx && ack_ok && (buf_level != '0)
                 && (c_rpt || !cnt_zero);
      do_recv  = in_run && !do_stop && !c_tx && (buf_level < FULL_LVL)
                 && (c_rpt || !cnt_zero);
      pass_end = in_run && !do_stop && !do_send && !do_recv;
      pass_eval = (pass_end || do_stop) && !c_rpt;
   end

   assign start_done = (st == S_START) && eng_done;
   assign send_done  = (st == S_SEND)  && eng_done;
   assign recv_done  = (st == S_RECV)  && eng_done;
   assign stop_done  = (st == S_STOP)  && eng_done;

   assign clr_master = pass_eval && cnt_zero && (c_tx || !c_stop);
   assign clr_stop   = ((start_done || send_done) && !eng_ack) || stop_done;
   assign cnt_load   = (start_done && eng_ack) || stop_done;
   assign cnt_dec    = !c_rpt && (send_done || recv_done);

   // flag updates
   always_comb begin
      fl_upd = '0;
      fl_val = '0;
      if ((start_done || send_done) && !eng_ack) begin
         fl_upd[FL_NACK] = 1'b1;
         fl_val[FL_NACK] = 1'b1;
      end
      if (clr_master) begin
         fl_upd[FL_ARDY] = 1'b1;
         fl_val[FL_ARDY] = 1'b1;
      end
      if (pass_eval) begin
         if (c_tx) begin
            fl_upd[FL_XRDY] = 1'b1;
            fl_val[FL_XRDY] = ack_ok && !cnt_zero;
         end else begin
            fl_upd[FL_RRDY] = 1'b1;
            fl_val[FL_RRDY] = (buf_level != '0);
         end
      end else if (pass_end && c_rpt) begin
         fl_upd[FL_XRDY] = c_tx;
         fl_val[FL_XRDY] = c_tx;
         fl_upd[FL_RRDY] = !c_tx;
         fl_val[FL_RRDY] = !c_tx;
      end
   end

   // engine and buffer strobes
   assign eng_start   = go;
   assign eng_addr    = tgt_addr;
   assign eng_read    = !ctl_tx;
   assign eng_send    = do_send;
   assign eng_tx_byte = buf_rd_data;
   assign eng_recv    = do_recv;
   assign eng_stop    = do_stop;
   assign buf_pop     = do_send;
   assign buf_push    = recv_done;
   assign buf_wr_data = eng_rx_byte;
   assign buf_flush   = go || stop_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         bus_open <= 1'b0;
         ack_ok   <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (go) st <= S_START;
               else if (data_kick && bus_open) begin
                  st     <= S_RUN;
                  ack_ok <= 1'b1;
               end
            end
            S_START: if (eng_done) begin
               bus_open <= eng_ack;
               ack_ok   <= eng_ack;
               st       <= eng_ack ? S_RUN : S_IDLE;
            end
            S_RUN: begin
               if (do_stop)      st <= S_STOP;
               else if (do_send) st <= S_SEND;
               else if (do_recv) st <= S_RECV;
               else              st <= S_IDLE;
            end
            S_SEND: if (eng_done) begin
               if (!eng_ack) ack_ok <= 1'b0;
               st <= S_RUN;
            end
            S_RECV: if (eng_done) st <= S_RUN;
            S_STOP: if (eng_done) begin
               bus_open <= 1'b0;
               st       <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({eng_start, eng_send, eng_recv, eng_stop}));
   p_send_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_send |-> (buf_level != '0) && bus_open);
   p_recv_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_recv |-> buf_level < FULL_LVL);
   p_start_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_done && !eng_ack) |=> flag_nack && !stop_pend && !bus_open);
   p_stop_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_done |=> !bus_open && !stop_pend && work_count == $past(prog_count));
   p_closed_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !bus_open) |-> !(eng_send || eng_recv || eng_stop));
   p_send_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (send_done && !eng_ack) |=> flag_nack && !stop_pend && !eng_send);
endmodule

// File: tb/i2c_xfer_seq_tb.sv
`timescale 1ns/1ps
module i2c_xfer_seq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic ctl_wr = 0, ctl_en = 0, ctl_master = 0, ctl_tx = 0, ctl_addr10 = 0;
   logic ctl_repeat = 0, ctl_stop = 0, ctl_start = 0;
   logic [9:0]  tgt_addr = 10'h05A;
   logic [15:0] prog_count = 16'd0;
   logic data_kick = 0;
   logic [3:0] flag_clr = 4'h0;
   logic [2:0] buf_level;
   logic [7:0] buf_rd_data, buf_wr_data, eng_tx_byte, eng_rx_byte;
   logic buf_pop, buf_push, buf_flush, eng_start, eng_read, eng_send, eng_recv, eng_stop;
   logic [9:0] eng_addr;
   logic eng_done, eng_ack;
   logic flag_nack, flag_ardy, flag_xrdy, flag_rrdy, master_on, stop_pend, bus_open, start_rej;
   logic [15:0] work_count;

   i2c_xfer_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_master(ctl_master),
      .ctl_tx(ctl_tx), .ctl_addr10(ctl_addr10), .ctl_repeat(ctl_repeat), .ctl_stop(ctl_stop),
      .ctl_start(ctl_start), .tgt_addr(tgt_addr), .prog_count(prog_count),
      .data_kick(data_kick), .flag_clr(flag_clr), .buf_level(buf_level),
      .buf_rd_data(buf_rd_data), .buf_pop(buf_pop), .buf_push(buf_push),
      .buf_wr_data(buf_wr_data), .buf_flush(buf_flush), .eng_start(eng_start),
      .eng_addr(eng_addr), .eng_read(eng_read), .eng_send(eng_send),
      .eng_tx_byte(eng_tx_byte), .eng_recv(eng_recv), .eng_stop(eng_stop),
      .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx_byte(eng_rx_byte),
      .flag_nack(flag_nack), .flag_ardy(flag_ardy), .flag_xrdy(flag_xrdy),
      .flag_rrdy(flag_rrdy), .work_count(work_count), .master_on(master_on),
      .stop_pend(stop_pend), .bus_open(bus_open), .start_rej(start_rej)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ---------------- packing buffer model ----------------
   logic [7:0] bm [0:3];
   int bl;
   logic cpu_wr = 0, cpu_clr = 0;
   logic [7:0] cpu_byte = 0;
   assign buf_level   = 3'(bl);
   assign buf_rd_data = bm[0];

   always @(posedge clk) begin : bufm
      int nl;
      if (!rst_n) bl <= 0;
      else if (buf_flush || cpu_clr) bl <= 0;
      else begin
         nl = bl;
         if (buf_pop && nl > 0) begin
            for (int i = 0; i < 3; i++) bm[i] <= bm[i+1];
            nl = nl - 1;
         end
         if (buf_push && nl < 4) begin bm[nl] <= buf_wr_data; nl = nl + 1; end
         if (cpu_wr && nl < 4)   begin bm[nl] <= cpu_byte;    nl = nl + 1; end
         bl <= nl;
      end
   end

   // ---------------- bus engine model ----------------
   int lat = 0, kind = 0;
   int n_start = 0, n_send = 0, n_recv = 0, n_stop = 0;
   int nack_at = -1;
   bit start_ack = 1;
   logic [9:0] last_addr = 0;
   logic last_read = 0;
   logic [7:0] rx_next = 8'hA0;

   always @(posedge clk) begin
      if (!rst_n) begin
         eng_done <= 0; eng_ack <= 0; eng_rx_byte <= 0; lat <= 0;
      end else begin
         eng_done <= 0;
         if (eng_start) begin
            lat <= 2; kind <= 0; n_start <= n_start + 1;
            last_addr <= eng_addr; last_read <= eng_read;
         end else if (eng_send) begin lat <= 2; kind <= 1;
         end else if (eng_recv) begin lat <= 2; kind <= 2; n_recv <= n_recv + 1;
         end else if (eng_stop) begin lat <= 2; kind <= 3; n_stop <= n_stop + 1;
         end else if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
               eng_done <= 1;
               case (kind)
                  0: eng_ack <= start_ack;
                  1: begin eng_ack <= (n_send != nack_at); n_send <= n_send + 1; end
                  2: begin eng_ack <= 1; eng_rx_byte <= rx_next; rx_next <= rx_next + 1; end
                  default: eng_ack <= 1;
               endcase
            end
         end
      end
   end

   // ---------------- scoreboard ----------------
   logic [7:0] exp_q[$];

   always @(negedge clk) begin
      if (rst_n && eng_send) begin
         if (exp_q.size() == 0) check("R5 unexpected send", int'(eng_tx_byte), -1);
         else check("R5 send byte order", int'(eng_tx_byte), int'(exp_q.pop_front()));
      end
   end

   // ---------------- driver tasks ----------------
   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl(bit en, bit m, bit tx, bit a10, bit rpt, bit stp, bit stt);
      @(negedge clk);
      ctl_wr = 1; ctl_en = en; ctl_master = m; ctl_tx = tx; ctl_addr10 = a10;
      ctl_repeat = rpt; ctl_stop = stp; ctl_start = stt;
      @(negedge clk);
      ctl_wr = 0; ctl_start = 0;
   endtask

   task automatic load(logic [7:0] b, bit expect_it);
      @(negedge clk);
      cpu_wr = 1; cpu_byte = b;
      if (expect_it) exp_q.push_back(b);
      @(negedge clk);
      cpu_wr = 0;
   endtask

   task automatic kick();
      @(negedge clk); data_kick = 1;
      @(negedge clk); data_kick = 0;
   endtask

   task automatic clr_all();
      @(negedge clk); flag_clr = 4'hF; cpu_clr = 1;
      @(negedge clk); flag_clr = 4'h0; cpu_clr = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      int req0;
      cyc(5);
      rst_n = 1;
      cyc(2);
      // reset state
      check("R13 reset flags", int'({flag_nack, flag_ardy, flag_xrdy, flag_rrdy}), 0);
      check("R11 reset count", int'(work_count), 0);
      check("R12 reset bus", int'(bus_open), 0);

      // R1: illegal starts
      @(negedge clk);
      ctl_wr = 1; ctl_en = 1; ctl_master = 0; ctl_start = 1;
      #1 check("R1 slave start rejected", int'(start_rej), 1);
      @(negedge clk);
      ctl_master = 1; ctl_addr10 = 1;
      #1 check("R1 10-bit start rejected", int'(start_rej), 1);
      @(negedge clk);
      ctl_en = 0; ctl_addr10 = 0;
      #1 check("R1 disabled start silent", int'(start_rej), 0);
      @(negedge clk);
      ctl_wr = 0; ctl_start = 0;
      cyc(10);
      check("R1 no bus start", n_start, 0);

      // R3: start not acknowledged
      start_ack = 0; tgt_addr = 10'h1A5;
      ctl(1, 1, 1, 0, 0, 1, 1);
      cyc(20);
      check("R2 start count", n_start, 1);
      check("R2 start address", int'(last_addr), 'h1A5);
      check("R2 start direction write", int'(last_read), 0);
      check("R3 nack flag", int'(flag_nack), 1);
      check("R3 stop cancelled", int'(stop_pend), 0);
      check("R3 bus closed", int'(bus_open), 0);
      start_ack = 1;
      clr_all();
      check("R13 flags cleared", int'({flag_nack, flag_ardy, flag_xrdy, flag_rrdy}), 0);

      // counted transmit, count 3, stop
      prog_count = 16'd3;
      ctl(1, 1, 1, 0, 0, 1, 1);
      cyc(20);
      check("R4 bus open", int'(bus_open), 1);
      check("R4 counter loaded", int'(work_count), 3);
      check("R6 xrdy empty pass", int'(flag_xrdy), 1);
      load(8'h11, 1); load(8'h22, 1);
      kick();
      cyc(40);
      check("R5 sent two", n_send, 2);
      check("R11 live counter", int'(work_count), 1);
      check("R6 xrdy mid", int'(flag_xrdy), 1);
      check("R8 no ardy yet", int'(flag_ardy), 0);
      load(8'h33, 1);
      kick();
      cyc(40);
      check("R8 stop issued", n_stop, 1);
      check("R8 bus closed", int'(bus_open), 0);
      check("R8 counter reloaded", int'(work_count), 3);
      check("R8 stop cleared", int'(stop_pend), 0);
      check("R8 ardy at zero tx", int'(flag_ardy), 1);
      check("R8 master cleared", int'(master_on), 0);
      check("R6 xrdy at zero", int'(flag_xrdy), 0);
      clr_all();

      // counted receive, count 6, no stop
      prog_count = 16'd6;
      ctl(1, 1, 0, 0, 0, 0, 1);
      cyc(40);
      check("R2 start direction read", int'(last_read), 1);
      check("R7 fill to four", bl, 4);
      check("R7 first byte", int'(bm[0]), 'hA0);
      check("R7 last byte", int'(bm[3]), 'hA3);
      check("R7 rrdy", int'(flag_rrdy), 1);
      check("R11 counter after rx", int'(work_count), 2);
      clr_all();
      kick();
      cyc(40);
      check("R7 two more", bl, 2);
      check("R7 byte order", int'(bm[1]), 'hA5);
      check("R8 ardy no stop", int'(flag_ardy), 1);
      check("R8 master cleared rx", int'(master_on), 0);
      check("R8 bus stays open", int'(bus_open), 1);
      check("R8 no stop", n_stop, 1);
      clr_all();

      // data NACK on second byte
      prog_count = 16'd4;
      ctl(1, 1, 1, 0, 0, 1, 1);
      cyc(20);
      nack_at = n_send + 1;
      load(8'h44, 1); load(8'h55, 1); load(8'h66, 0);
      kick();
      cyc(40);
      check("R10 nack flag", int'(flag_nack), 1);
      check("R10 stop cancelled", int'(stop_pend), 0);
      check("R10 third byte held", bl, 1);
      check("R6 xrdy after nack", int'(flag_xrdy), 0);
      check("R10 counter", int'(work_count), 2);
      nack_at = -1;
      clr_all();

      // repeat transmit
      prog_count = 16'd5;
      ctl(1, 1, 1, 0, 1, 0, 1);
      cyc(20);
      load(8'h71, 1); load(8'h72, 1); load(8'h73, 1);
      @(negedge clk); flag_clr = 4'hF; @(negedge clk); flag_clr = 4'h0;
      kick();
      cyc(40);
      check("R9 drained", bl, 0);
      check("R9 xrdy", int'(flag_xrdy), 1);
      check("R9 count untouched", int'(work_count), 5);
      check("R9 no ardy", int'(flag_ardy), 0);
      clr_all();

      // repeat receive then stop
      ctl(1, 1, 0, 0, 1, 0, 1);
      cyc(40);
      check("R9 rx filled", bl, 4);
      check("R9 rrdy", int'(flag_rrdy), 1);
      check("R9 rx byte", int'(bm[0]), 'hA6);
      ctl(1, 1, 0, 0, 1, 1, 0);
      req0 = n_recv;
      kick();
      cyc(30);
      check("R9 repeat stop", n_stop, 2);
      check("R9 no receive on stop", n_recv, req0);
      check("R9 bus closed", int'(bus_open), 0);

      // R12: kick while closed
      req0 = n_start + n_send + n_recv + n_stop;
      kick();
      cyc(20);
      check("R12 closed kick silent", n_start + n_send + n_recv + n_stop, req0);
      check("R5 scoreboard drained", exp_q.size(), 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule